// File: doc/BRIEF.md
# Receive-Side RTS Hysteresis Controller

This block drives the active-low request-to-send line of a UART receiver. Each clock it compares the receive FIFO fill count (0 to 128 characters) with a window built around the programmed receive trigger level. It withdraws RTS (drives it high) once the count climbs to the top edge of the window. It grants RTS again (drives it low) once the count drains to the bottom edge. Between the edges the line keeps its last value, so the far transmitter is not throttled on every character.

The window half-width H comes from a 4-bit select code. The two upper select bits come from one enhanced-mode register and the two lower bits from a feature-control register; the decode of those registers lies outside this block. The width table does not grow steadily with the code. Code 0000 has no symmetric band: RTS is withdrawn at the trigger level itself and granted again one character below it. When automatic RTS is turned off, the line is held asserted. The output is registered.

Top module: `rts_hyst_ctrl`

## Requirements
- R1: `hyst_sel` is {enhanced bit 5, enhanced bit 4, feature bit 1, feature bit 0} with bit 3 first; codes 0001, 0010 and 0011 give H = 4, 6 and 8 characters.
- R2: Codes 0100, 0101, 0110 and 0111 give H = 8, 16, 24 and 32.
- R3: Codes 1000 to 1111, in ascending order, give H = 12, 20, 28, 36, 40, 44, 48 and 52.
- R4: With auto-RTS enabled and a nonzero code, `rts_n` goes to 1 when `rx_count` >= trigger + H.
- R5: With auto-RTS enabled and a nonzero code, `rts_n` goes to 0 when `rx_count` <= trigger − H and the upper condition of R4 is false.
- R6: While `rx_count` lies strictly between the lower and upper thresholds, `rts_n` keeps its previous value.
- R7: Both thresholds are clamped to 0..128. An upper sum above 128 becomes 128, and a negative lower difference becomes 0.
- R8: For code 0000, `rts_n` goes to 1 when `rx_count` >= trigger and goes to 0 when `rx_count` < trigger.
- R9: When `auto_rts_en` is 0, `rts_n` is 0 on the next clock, whatever the count.
- R10: During reset `rts_n` is 0. When the upper and lower conditions hold at once (only with clamping, such as trigger 0 with code 0000 and count 0), the upper condition wins and `rts_n` goes to 1.
- R11: `rts_n` is registered. A threshold crossing on the inputs shows on `rts_n` after the next rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_count | input | 8 | Receive FIFO fill count, 0..128 |
| rx_trig | input | 8 | Receive trigger level, 0..128 |
| hyst_sel | input | 4 | Hysteresis select code |
| auto_rts_en | input | 1 | Automatic RTS enable |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
Two decisions can compete in one cycle. The first pair is the withdraw and re-grant conditions: both become true only when clamping collapses the window. The bench provokes this with trigger 0, code 0000 and a count of 0, and expects withdrawal. The second pair is the disable override and a count at or above the upper threshold: the bench drops the enable while the FIFO is full and expects RTS asserted after that edge. Every result is compared against a queue of values that the bench predicts from its own threshold model.

// File: rtl/rts_hyst_pkg.sv
// Package: shared types and the hysteresis width table for the RTS controller.
// Assumes: the select code is 4 bits; code 0 is the "next level" mode and maps to width 0.
package rts_hyst_pkg;

    localparam int HSEL_W = 4;
    localparam int SPAN_W = 6;

    // Level driven on the active-low RTS line.
    typedef enum logic {
        RTS_GRANT    = 1'b0,
        RTS_WITHHOLD = 1'b1
    } rts_lvl_e;

    // Half-width of the hysteresis band in characters for each select code.
    function automatic logic [SPAN_W-1:0] hyst_span(input logic [HSEL_W-1:0] code);
        logic [SPAN_W-1:0] w;
        case (code)
            4'b0001: w = 6'd4;
            4'b0010: w = 6'd6;
            4'b0011: w = 6'd8;
            4'b0100: w = 6'd8;
            4'b0101: w = 6'd16;
            4'b0110: w = 6'd24;
            4'b0111: w = 6'd32;
            4'b1000: w = 6'd12;
            4'b1001: w = 6'd20;
            4'b1010: w = 6'd28;
            4'b1011: w = 6'd36;
            4'b1100: w = 6'd40;
            4'b1101: w = 6'd44;
            4'b1110: w = 6'd48;
            4'b1111: w = 6'd52;
            default: w = 6'd0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/rts_hyst_span.sv
// Module: rts_hyst_span
// Decodes the select code into a band half-width and a next-level mode flag.
// Assumes: CNT_W >= rts_hyst_pkg::SPAN_W; purely combinational.
module rts_hyst_span
    import rts_hyst_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [HSEL_W-1:0] sel,
    output logic [CNT_W-1:0]  span,
    output logic              next_level
);

    localparam int PAD_W = CNT_W - SPAN_W;

    logic [SPAN_W-1:0] raw_span;

    // Look up the table width and widen it to the count width.
    always_comb begin
        raw_span   = hyst_span(sel);
        span       = {{PAD_W{1'b0}}, raw_span};
        next_level = (sel == '0);
    end

endmodule

// File: rtl/rts_hyst_bounds.sv
// Module: rts_hyst_bounds
// Forms the clamped upper and lower thresholds around the trigger level.
// Assumes: DEPTH fits in CNT_W bits; in next-level mode the lower edge is trigger-1.
module rts_hyst_bounds #(
    parameter int DEPTH = 128,
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] trig,
    input  logic [CNT_W-1:0] span,
    input  logic             next_level,
    output logic [CNT_W-1:0] upper,
    output logic [CNT_W-1:0] lower
);

    localparam int          EXT_W   = CNT_W + 1;
    localparam logic [EXT_W-1:0] DEPTH_X = EXT_W'(DEPTH);

    logic [EXT_W-1:0] up_sum;
    logic [EXT_W-1:0] lo_step;
    logic [EXT_W-1:0] lo_diff;

    // Top edge: trigger plus half-width, saturated at the FIFO depth.
    always_comb begin
        up_sum = {1'b0, trig} + {1'b0, span};
        upper  = (up_sum > DEPTH_X) ? DEPTH_X[CNT_W-1:0] : up_sum[CNT_W-1:0];
    end

    // Bottom edge: trigger minus half-width (or one), floored at zero.
    always_comb begin
        lo_step = next_level ? EXT_W'(1) : {1'b0, span};
        lo_diff = {1'b0, trig} - lo_step;
        if (lo_diff[CNT_W]) begin
            lower = '0;
        end else if (lo_diff > DEPTH_X) begin
            lower = DEPTH_X[CNT_W-1:0];
        end else begin
            lower = lo_diff[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/rts_hyst_state.sv
// Module: rts_hyst_state
// Holds the registered RTS level and applies withdraw / grant / hold decisions.
// Assumes: thresholds are already clamped; withdraw beats grant; disable beats both.
module rts_hyst_state
    import rts_hyst_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] upper,
    input  logic [CNT_W-1:0] lower,
    output logic             rts_n
);

    rts_lvl_e lvl_q;
    rts_lvl_e lvl_d;
    logic     hit_upper;
    logic     hit_lower;

    // Compare the fill count against both edges of the band.
    always_comb begin
        hit_upper = (count >= upper);
        hit_lower = (count <= lower);
    end

    // Choose the next level: disabled grants, upper withholds, lower grants, else hold.
    always_comb begin
        if (!enable) begin
            lvl_d = RTS_GRANT;
        end else if (hit_upper) begin
            lvl_d = RTS_WITHHOLD;
        end else if (hit_lower) begin
            lvl_d = RTS_GRANT;
        end else begin
            lvl_d = lvl_q;
        end
    end

    // Register the level; reset grants RTS.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= RTS_GRANT;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign rts_n = lvl_q;

    // R9: disable forces RTS asserted on the next edge
    assert_disabled_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !rts_n);

    // R4: reaching the top edge withdraws RTS (also covers the R10 tie)
    assert_upper_withhold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && count >= upper) |=> rts_n);

    // R5: reaching the bottom edge below the top grants RTS
    assert_lower_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && count < upper && count <= lower) |=> !rts_n);

    // R6: inside the band the line is held
    assert_band_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && count < upper && count > lower) |=> $stable(rts_n));

    // R7: thresholds stay within the FIFO range and ordered
    assert_bounds_clamped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upper <= CNT_W'(DEPTH)) && (lower <= upper));

endmodule

// File: rtl/rts_hyst_ctrl.sv
// Module: rts_hyst_ctrl (top)
// RTS flow control with a trigger-centred hysteresis band for a UART receiver.
// Assumes: rx_count and rx_trig are within 0..DEPTH; synchronous active-low reset.
module rts_hyst_ctrl
    import rts_hyst_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  rx_trig,
    input  logic [HSEL_W-1:0] hyst_sel,
    input  logic              auto_rts_en,
    output logic              rts_n
);

    logic [CNT_W-1:0] span;
    logic             next_level;
    logic [CNT_W-1:0] upper;
    logic [CNT_W-1:0] lower;

    rts_hyst_span #(
        .CNT_W (CNT_W)
    ) u_span (
        .sel        (hyst_sel),
        .span       (span),
        .next_level (next_level)
    );

    rts_hyst_bounds #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_bounds (
        .trig       (rx_trig),
        .span       (span),
        .next_level (next_level),
        .upper      (upper),
        .lower      (lower)
    );

    rts_hyst_state #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (auto_rts_en),
        .count  (rx_count),
        .upper  (upper),
        .lower  (lower),
        .rts_n  (rts_n)
    );

endmodule

// File: tb/sim_rts_hyst_ctrl.sv
`timescale 1ns/1ps
// Bench: scoreboard around rts_hyst_ctrl. The driver predicts, the monitor compares after each edge.
module sim_rts_hyst_ctrl;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_count = 8'd128;
    logic [7:0] rx_trig = 8'd0;
    logic [3:0] hyst_sel = 4'd0;
    logic       auto_rts_en = 1'b1;
    logic       rts_n;

    int    n_tests = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    logic  model = 1'b0;
    item_t sbq[$];

    always #2 clk = ~clk;

    rts_hyst_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_count    (rx_count),
        .rx_trig     (rx_trig),
        .hyst_sel    (hyst_sel),
        .auto_rts_en (auto_rts_en),
        .rts_n       (rts_n)
    );

    // Width table written from the requirements R1..R3.
    function automatic int span_of(input logic [3:0] c);
        int t[16] = '{0, 4, 6, 8, 8, 16, 24, 32, 12, 20, 28, 36, 40, 44, 48, 52};
        return t[c];
    endfunction

    function automatic int up_of(input int trig, input logic [3:0] c);
        int u = (c == 0) ? trig : trig + span_of(c);
        return (u > 128) ? 128 : u;
    endfunction

    function automatic int lo_of(input int trig, input logic [3:0] c);
        int l = (c == 0) ? trig - 1 : trig - span_of(c);
        return (l < 0) ? 0 : l;
    endfunction

    function automatic string tag_of(input logic [3:0] c);
        if (c == 0) return "R8";
        if (c < 4) return "R1";
        if (c < 8) return "R2";
        return "R3";
    endfunction

    task automatic check(input logic got, input logic exp, input string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: rts_n=%b expected %b", tag, got, exp);
        end
    endtask

    // Driver: apply inputs at the falling edge and queue the predicted level.
    task automatic drive(input int cnt, input int trig, input logic [3:0] c,
                         input logic en, input string tag);
        item_t it;
        int up, lo;
        @(negedge clk);
        rx_count    = 8'(cnt);
        rx_trig     = 8'(trig);
        hyst_sel    = c;
        auto_rts_en = en;
        up = up_of(trig, c);
        lo = lo_of(trig, c);
        if (!en)            model = 1'b0;
        else if (cnt >= up) model = 1'b1;
        else if (cnt <= lo) model = 1'b0;
        it.exp = model;
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: just after each rising edge, compare against the oldest prediction.
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            check(rts_n, it.exp, it.tag);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: reset holds RTS asserted even with a full FIFO
        repeat (3) @(negedge clk);
        check(rts_n, 1'b0, "R10");
        rst_n = 1'b1;
        model = 1'b0;

        // R9: disabled while full
        drive(128, 0, 4'd1, 1'b0, "R9");

        // R4/R5/R6 walk with trigger 64, H=4
        drive(60, 64, 4'd1, 1'b1, "R5");
        drive(67, 64, 4'd1, 1'b1, "R6");
        drive(68, 64, 4'd1, 1'b1, "R4");
        drive(65, 64, 4'd1, 1'b1, "R6");
        drive(61, 64, 4'd1, 1'b1, "R6");
        drive(60, 64, 4'd1, 1'b1, "R5");

        // R11: the crossing is not visible before the edge
        drive(68, 64, 4'd1, 1'b1, "R11");
        #1;
        check(rts_n, 1'b0, "R11");
        drive(60, 64, 4'd1, 1'b1, "R11");
        #1;
        check(rts_n, 1'b1, "R11");

        // R1/R2/R3/R8: every code around trigger 64
        for (int c = 0; c < 16; c++) begin
            int up = up_of(64, 4'(c));
            int lo = lo_of(64, 4'(c));
            drive(lo, 64, 4'(c), 1'b1, tag_of(4'(c)));
            drive(up - 1, 64, 4'(c), 1'b1, tag_of(4'(c)));
            drive(up, 64, 4'(c), 1'b1, tag_of(4'(c)));
            drive(lo + 1, 64, 4'(c), 1'b1, tag_of(4'(c)));
            drive(lo, 64, 4'(c), 1'b1, tag_of(4'(c)));
        end

        // R7: clamping at the top and at zero
        drive(127, 100, 4'd15, 1'b1, "R7");
        drive(128, 100, 4'd15, 1'b1, "R7");
        drive(48, 100, 4'd15, 1'b1, "R7");
        drive(127, 100, 4'd15, 1'b1, "R7");
        drive(128, 20, 4'd15, 1'b1, "R7");
        drive(1, 20, 4'd15, 1'b1, "R7");
        drive(0, 20, 4'd15, 1'b1, "R7");

        // R8: next-level mode at trigger 10
        drive(9, 10, 4'd0, 1'b1, "R8");
        drive(10, 10, 4'd0, 1'b1, "R8");
        drive(9, 10, 4'd0, 1'b1, "R8");

        // R10: both conditions at once, withdraw wins
        drive(0, 0, 4'd0, 1'b1, "R10");
        // R9: disable beats a count above the top edge
        drive(128, 0, 4'd0, 1'b0, "R9");
        drive(128, 0, 4'd0, 1'b1, "R4");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule